// File: doc/BRIEF.md
# Zero-Address Stack Execution Unit

This block executes operations of a stack machine one at a time. Values sit in a small operand stack held in registers. A push copies a word from data memory onto the stack. A pop copies the top word back to data memory. An add replaces the two topmost words with their sum. Add names no operands: it always works on the two newest entries. A statement such as `A = B + C` therefore becomes the sequence push C, push B, add, pop A.

The stack position is kept as a byte offset that moves one word (4 bytes) per step. After reset it holds a value that means "no entries". The memory port is synchronous, and read data arrives one cycle after the read strobe. Each operation is started with a one-cycle `start`, which is taken only while the unit is idle. Completion is signalled by a one-cycle `done`. Operations that would overrun the stack, or that need more entries than the stack holds, are turned away: they change nothing and set a sticky error flag.

Top module: `stk_core`

## Requirements
- R1: After reset the stack is empty, `done`, `mem_rd`, `mem_wr`, `overflow` and `underflow` are low, and sixteen pushes can then be made without an overflow.
- R2: Push (op code 2'b01) is accepted at a clock edge. In the next cycle the unit drives `mem_rd` high with `mem_addr` equal to the given address. In the cycle after that, `done` is high and the returned word becomes the new top entry.
- R3: Pop (op code 2'b10) drives `mem_wr` high in the cycle after acceptance, with `mem_addr` equal to the given address and `mem_wdata` equal to the top entry. `done` is high in that same cycle, and the entry then leaves the stack.
- R4: Add (op code 2'b11) ignores `addr` and touches no memory. It stores the sum of the two top entries, modulo 2^32, in the lower of the two slots, shrinks the stack by one entry, and raises `done` in the cycle after acceptance.
- R5: Entries leave the stack in the reverse order of entry. The sequence push C, push B, add, pop A stores B+C at address A.
- R6: A push onto a stack that holds 16 entries issues no memory read, leaves the contents unchanged, sets `overflow`, and raises `done` in the cycle after acceptance.
- R7: A pop on an empty stack, or an add on a stack with fewer than two entries, issues no memory access, leaves the contents unchanged, sets `underflow`, and raises `done` in the cycle after acceptance.
- R8: Every accepted operation produces exactly one `done` pulse that lasts one cycle. Op code 2'b00 is a no-operation that completes in the cycle after acceptance and touches no memory.
- R9: While an operation is in progress, `start` is ignored.
- R10: `overflow` and `underflow` stay high until reset once they are set.
- R11: `mem_rd` and `mem_wr` are never high together. Any memory access uses the address latched when the operation was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin an operation; taken only when idle |
| op | input | 2 | 00 nop, 01 push, 10 pop, 11 add |
| addr | input | 8 | Word address in data memory for push or pop |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 8 | Memory word address |
| mem_rd | output | 1 | Memory read strobe; data is returned one cycle later |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Data written to memory |
| mem_rdata | input | 32 | Data read from memory |
| overflow | output | 1 | Sticky flag: a push was refused because the stack was full |
| underflow | output | 1 | Sticky flag: a pop or add was refused for lack of entries |

## Verification
The assertions check the following on every cycle:
- The stack fill only ever moves by one entry per step, and never exceeds the depth.
- `done` never lasts longer than a single cycle.
- A read is always followed by completion in the next cycle.
- A push onto a full stack never raises a read.
- The read and write strobes never overlap.
- The error flags never drop once set.

Only the bench's scenarios can show the rest:
- Data lands in the right slots.
- Entries leave in reverse order.
- Sums wrap modulo 2^32.
- A refused operation leaves the stored values intact.
- A start given during a busy cycle produces no second operation.

// File: rtl/stk_pkg.sv
package stk_pkg;

  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned WORD_SHIFT = 2;

  typedef enum logic [1:0] {
    OP_NOP  = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_ADD  = 2'b11
  } stk_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_STORE,
    ST_SUM,
    ST_NOP,
    ST_OVF,
    ST_UNF
  } stk_state_e;

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr
  import stk_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         inc,
  input  logic                         dec,
  output logic [$clog2(DEPTH)-1:0]     top_idx,
  output logic [$clog2(DEPTH)-1:0]     below_idx,
  output logic [$clog2(DEPTH)-1:0]     up_idx,
  output logic [$clog2(DEPTH):0]       fill
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = IDX_W + 1;
  localparam int unsigned PTR_W = IDX_W + WORD_SHIFT + 1;
  localparam logic [PTR_W-1:0] SP_EMPTY = PTR_W'(0) - PTR_W'(WORD_BYTES);

  // byte offset of the top entry; one word below slot 0 when empty
  logic [PTR_W-1:0] sp_q;

  function automatic logic [PTR_W-1:0] step_up(input logic [PTR_W-1:0] s);
    return s + PTR_W'(WORD_BYTES);
  endfunction

  function automatic logic [PTR_W-1:0] step_dn(input logic [PTR_W-1:0] s);
    return s - PTR_W'(WORD_BYTES);
  endfunction

  function automatic logic [CNT_W-1:0] fill_of(input logic [PTR_W-1:0] s);
    logic [PTR_W-1:0] t;
    t = s + PTR_W'(WORD_BYTES);
    return t[PTR_W-1:WORD_SHIFT];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sp_q <= SP_EMPTY;
    else if (inc) sp_q <= step_up(sp_q);
    else if (dec) sp_q <= step_dn(sp_q);
  end

  assign top_idx   = sp_q[PTR_W-2:WORD_SHIFT];
  assign below_idx = top_idx - IDX_W'(1);
  assign up_idx    = top_idx + IDX_W'(1);
  assign fill      = fill_of(sp_q);

  // R2: a push step adds exactly one entry
  a_r2_ptr_rise: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> fill == $past(fill) + CNT_W'(1));
  // R3: a pop or add step removes exactly one entry
  a_r3_ptr_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc) |=> fill == $past(fill) - CNT_W'(1));
  // R4: the pointer never moves both ways in one cycle
  a_r4_single_move: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc && dec));
  // R6: the stack never holds more than its depth
  a_r6_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH));

endmodule

// File: rtl/stk_regs.sv
module stk_regs #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [$clog2(DEPTH)-1:0]  widx,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [$clog2(DEPTH)-1:0]  ridx_a,
  input  logic [$clog2(DEPTH)-1:0]  ridx_b,
  output logic [DATA_W-1:0]         rdata_a,
  output logic [DATA_W-1:0]         rdata_b
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [DATA_W-1:0] slot_q [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we && widx == IDX_W'(i)) slot_q[i] <= wdata;
    end
  end

  assign rdata_a = slot_q[ridx_a];
  assign rdata_b = slot_q[ridx_b];

endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  stk_op_e                 op,
  input  logic [$clog2(DEPTH):0]  fill,
  output logic                    accept,
  output logic                    in_fetch,
  output logic                    in_load,
  output logic                    in_store,
  output logic                    in_sum,
  output logic                    done,
  output logic                    ovf_flag,
  output logic                    unf_flag
);
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1;

  stk_state_e state_q, state_d;

  assign accept = start && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          unique case (op)
            OP_PUSH: state_d = (fill == CNT_W'(DEPTH)) ? ST_OVF : ST_FETCH;
            OP_POP:  state_d = (fill == '0) ? ST_UNF : ST_STORE;
            OP_ADD:  state_d = (fill < CNT_W'(2)) ? ST_UNF : ST_SUM;
            default: state_d = ST_NOP;
          endcase
        end
      end
      ST_FETCH: state_d = ST_LOAD;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_OVF) ovf_flag <= 1'b1;
      if (state_q == ST_UNF) unf_flag <= 1'b1;
    end
  end

  assign in_fetch = (state_q == ST_FETCH);
  assign in_load  = (state_q == ST_LOAD);
  assign in_store = (state_q == ST_STORE);
  assign in_sum   = (state_q == ST_SUM);
  assign done     = (state_q != ST_IDLE) && (state_q != ST_FETCH);

  // R8: completion lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: a read cycle always leads to the load cycle, whatever start does
  a_r9_busy_chain: assert property (@(posedge clk) disable iff (!rst_n)
    in_fetch |=> in_load);
  // R10: the error flags are sticky
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);
  a_r10_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unf_flag |=> unf_flag);

endmodule

// File: rtl/stk_core.sv
module stk_core
  import stk_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              overflow,
  output logic              underflow
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = IDX_W + 1;

  function automatic logic [DATA_W-1:0] wrap_sum(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  logic              accept, in_fetch, in_load, in_store, in_sum;
  logic [IDX_W-1:0]  top_idx, below_idx, up_idx;
  logic [CNT_W-1:0]  fill;
  logic [DATA_W-1:0] top_val, below_val;
  logic [ADDR_W-1:0] addr_q;
  logic              slot_we;
  logic [IDX_W-1:0]  slot_idx;
  logic [DATA_W-1:0] slot_data;

  stk_seq #(.DEPTH(DEPTH)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op       (stk_op_e'(op)),
    .fill     (fill),
    .accept   (accept),
    .in_fetch (in_fetch),
    .in_load  (in_load),
    .in_store (in_store),
    .in_sum   (in_sum),
    .done     (done),
    .ovf_flag (overflow),
    .unf_flag (underflow)
  );

  stk_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc       (in_load),
    .dec       (in_store | in_sum),
    .top_idx   (top_idx),
    .below_idx (below_idx),
    .up_idx    (up_idx),
    .fill      (fill)
  );

  assign slot_we   = in_load | in_sum;
  assign slot_idx  = in_load ? up_idx : below_idx;
  assign slot_data = in_load ? mem_rdata : wrap_sum(top_val, below_val);

  stk_regs #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .we      (slot_we),
    .widx    (slot_idx),
    .wdata   (slot_data),
    .ridx_a  (top_idx),
    .ridx_b  (below_idx),
    .rdata_a (top_val),
    .rdata_b (below_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= addr;
  end

  assign mem_addr  = addr_q;
  assign mem_rd    = in_fetch;
  assign mem_wr    = in_store;
  assign mem_wdata = top_val;

  // R11: the memory strobes never overlap
  a_r11_port_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R2: read data is consumed exactly one cycle after the read strobe
  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (done && !mem_rd));
  // R6: a push onto a full stack raises no read
  a_r6_full_noread: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_PUSH && fill == CNT_W'(DEPTH)) |=> (!mem_rd && done));
  // R7: a pop on an empty stack raises no write
  a_r7_empty_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_POP && fill == '0) |=> (!mem_wr && done));

endmodule

// File: tb/stk_core_test.sv
module stk_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [7:0]  addr = '0;
  logic        done, mem_rd, mem_wr, overflow, underflow;
  logic [7:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [256];
  logic [31:0] model [$];
  logic [39:0] exp_q [$];

  always #10 clk = ~clk;

  stk_core uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr),
    .done(done), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .overflow(overflow), .underflow(underflow)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: every memory write must match the next expected one
  always @(negedge clk) begin
    if (rst_n && mem_wr) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3", "unexpected write", {mem_addr, mem_wdata}, 0);
      end else begin
        logic [39:0] e;
        e = exp_q.pop_front();
        chk({mem_addr, mem_wdata} == e, "R3", "write addr/data",
            {mem_addr, mem_wdata}, e);
      end
    end
  end

  task automatic run_op(input logic [1:0] o, input logic [7:0] a, input int lat,
                        input string req, output bit saw_rd, output bit saw_wr);
    int done_at;
    int n_done;
    bit addr_ok;
    bit both;
    done_at = 0; n_done = 0; saw_rd = 0; saw_wr = 0; addr_ok = 1; both = 0;
    start = 1'b1; op = o; addr = a;
    @(negedge clk);
    start = 1'b0; op = 2'b00; addr = '0;
    for (int c = 1; c <= lat + 1; c++) begin
      if (c > 1) @(negedge clk);
      if (done) begin n_done++; if (done_at == 0) done_at = c; end
      if (mem_rd) begin saw_rd = 1; if (mem_addr != a) addr_ok = 0; end
      if (mem_wr) begin saw_wr = 1; if (mem_addr != a) addr_ok = 0; end
      if (mem_rd && mem_wr) both = 1;
    end
    chk(done_at == lat && n_done == 1, req, "done cycle (R8)", done_at, lat);
    chk(addr_ok && !both, "R11", "port address/exclusion", {addr_ok, both}, 2'b10);
  endtask

  task automatic do_push(input logic [7:0] a, input string req);
    bit r, w;
    if (model.size() < 16) begin
      model.push_back(mem[a]);
      run_op(2'b01, a, 2, req, r, w);
      chk(r && !w, req, "push reads memory", {r, w}, 2'b10);
    end else begin
      run_op(2'b01, a, 1, "R6", r, w);
      chk(!r && !w, "R6", "full push touches no memory", {r, w}, 0);
      chk(overflow, "R6", "overflow flag", overflow, 1);
    end
  endtask

  task automatic do_pop(input logic [7:0] a, input string req);
    bit r, w;
    if (model.size() > 0) begin
      exp_q.push_back({a, model.pop_back()});
      run_op(2'b10, a, 1, req, r, w);
      chk(w && !r, req, "pop writes memory", {r, w}, 2'b01);
    end else begin
      run_op(2'b10, a, 1, "R7", r, w);
      chk(!r && !w, "R7", "empty pop touches no memory", {r, w}, 0);
      chk(underflow, "R7", "underflow flag", underflow, 1);
    end
  endtask

  task automatic do_add(input logic [7:0] a, input string req);
    bit r, w;
    logic [31:0] x, y;
    if (model.size() >= 2) begin
      y = model.pop_back(); x = model.pop_back();
      model.push_back(x + y);
      run_op(2'b11, a, 1, req, r, w);
    end else begin
      run_op(2'b11, a, 1, "R7", r, w);
      chk(underflow, "R7", "underflow flag", underflow, 1);
    end
    chk(!r && !w, "R4", "add touches no memory", {r, w}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R8", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit r, w;
    int n_done;
    for (int i = 0; i < 256; i++) mem[i] = 32'h1000_0000 + 32'(i * 7);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!done && !mem_rd && !mem_wr, "R1", "outputs idle at reset",
        {done, mem_rd, mem_wr}, 0);
    chk(!overflow && !underflow, "R1", "flags clear at reset",
        {overflow, underflow}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: no-operation
    run_op(2'b00, 8'h33, 1, "R8", r, w);
    chk(!r && !w, "R8", "nop touches no memory", {r, w}, 0);

    // R5: A = B + C  as push C, push B, add, pop A
    mem[2] = 32'h0000_1234; mem[3] = 32'h0001_0001;
    do_push(8'd3, "R2");
    do_push(8'd2, "R2");
    do_add(8'hEE, "R4");
    do_pop(8'd1, "R5");
    @(negedge clk);
    chk(mem[1] == 32'h0001_1235, "R5", "A holds B+C", mem[1], 32'h0001_1235);

    // R4: sum wraps modulo 2^32
    mem[10] = 32'hFFFF_FFFF; mem[11] = 32'h0000_0002;
    do_push(8'd10, "R2");
    do_push(8'd11, "R2");
    do_add(8'h00, "R4");
    do_pop(8'd12, "R4");

    // R3: reverse order of entry
    for (int i = 0; i < 5; i++) do_push(8'(20 + i), "R2");
    for (int i = 0; i < 5; i++) do_pop(8'(60 + i), "R3");

    // R9: start held during a busy push
    model.push_back(mem[8'd30]);
    n_done = 0;
    start = 1'b1; op = 2'b01; addr = 8'd30;
    @(negedge clk);
    op = 2'b10; addr = 8'd99;
    if (done) n_done++;
    @(negedge clk);
    if (done) n_done++;
    @(negedge clk);
    start = 1'b0; op = 2'b00; addr = '0;
    if (done) n_done++;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      if (done) n_done++;
    end
    chk(n_done == 1, "R9", "one done for busy start", n_done, 1);
    do_pop(8'd70, "R9");

    // R6 / R1: fill sixteen, then one more
    for (int i = 0; i < 16; i++) do_push(8'(100 + i), "R1");
    chk(!overflow, "R1", "sixteen pushes fit", overflow, 0);
    do_push(8'd150, "R6");
    for (int i = 0; i < 16; i++) do_pop(8'(180 + i), "R6");

    // R7: empty pop, then add with a single entry
    chk(!underflow, "R7", "no underflow before", underflow, 0);
    do_pop(8'd200, "R7");
    do_push(8'd40, "R2");
    do_add(8'd0, "R7");
    do_pop(8'd201, "R7");

    // R10: flags remain after successful operations
    do_push(8'd41, "R2");
    do_pop(8'd202, "R2");
    chk(overflow && underflow, "R10", "flags sticky", {overflow, underflow}, 2'b11);

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "all expected writes seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule